// File: doc/BRIEF.md
# Pipelined Multiply-Add Arithmetic Slice

This block is a configurable arithmetic slice for signal-processing datapaths. Two signed 18-bit operands are multiplied. The 36-bit product is sign-extended to 48 bits and fed into a 48-bit post-adder.

The post-adder draws its inputs from three operand selectors. The first takes zero, the product or the slice's own output. The second takes zero, the product or the 48-bit C word. The third takes zero, a 48-bit word cascaded in from a neighbouring slice, the slice's own output or C. A 7-bit operation code picks these sources and may change on every clock cycle. The first two selections and a carry-in are summed. A subtract control then adds that sum to, or takes it away from, the third selection.

Each pipeline register is fitted or left out by parameter:
- the A and B operand chains take zero, one or two stages each;
- the product, the C word, the control bundle (operation code, subtract, carry-in) and the result each take zero or one stage.

The result is also driven on a cascade output. The delayed B operand is driven on its own cascade output, so that neighbouring slices can be chained into filters and wide accumulators.

Top module: `mac_slice`

## Requirements
- R1: With operation code 7'b000_01_01 (first selector field op[1:0]=01 and second field op[3:2]=01 both pick the product, third field op[6:4]=000 picks zero), P equals a×b as a two's complement product. The 36-bit result is sign-extended to 48 bits by repeating its top bit.
- R2: With sub=1, P = Z − (X + Y + cin). With sub=0, P = Z + X + Y + cin. Field op[6:4]=011 selects C as Z.
- R3: The carry-in enters the sum X+Y+cin. With operation code 0, sub=0 and cin=1, P is 1. With Z=C=0, sub=1 and cin=1, P wraps to all ones.
- R4: Field op[3:2]=11 selects C on the second selector. With operation code 7'b011_11_00, P equals 2×C modulo 2^48.
- R5: Field op[6:4]=001 selects the cascade input as Z.
- R6: The product code 01 must appear on both op[1:0] and op[3:2]. When it appears on only one of them, both the first and second selections are zero, and P = Z ± cin.
- R7: Operation code 7'b010_01_01 (Z takes P, field value 010) accumulates: each enabled result update adds the product to P.
- R8: Field op[1:0]=10 selects P on the first selector. With operation code 7'b000_11_10, each enabled update adds C to P.
- R9: A synchronous active-high reset clears every pipeline register, so P, the P cascade output and the B cascade output read zero.
- R10: Each stage holds its value while its own clock enable is low. This includes P under ce_p and the B chain under ce_b.
- R11: casc_out always equals P. With the default one B stage, b_casc equals the b value captured at the previous enabled edge.
- R12: With default parameters (one A stage, one product stage, one result stage), a change on a reaches P on the third rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous active-high clear of all stages |
| ce_a | input | 1 | Enable for the A operand stages |
| ce_b | input | 1 | Enable for the B operand stages |
| ce_c | input | 1 | Enable for the C stage |
| ce_m | input | 1 | Enable for the product stage |
| ce_ctl | input | 1 | Enable for the control stage |
| ce_p | input | 1 | Enable for the result stage |
| a | input | 18 | Signed multiplier operand |
| b | input | 18 | Signed multiplicand operand |
| c | input | 48 | Additive operand word |
| op | input | 7 | Operation code selecting the three operands |
| sub | input | 1 | 1: subtract the sum from Z, 0: add it |
| cin | input | 1 | Carry-in to the sum |
| casc_in | input | 48 | Cascade word from the neighbouring slice |
| p | output | 48 | Result |
| casc_out | output | 48 | Result forwarded to the next slice |
| b_casc | output | 18 | Delayed B operand forwarded to the next slice |

## Verification
The accumulation and illegal-code properties compare P with its previous value and with the registered product. They assume the default register layout, so that the control bundle and the product seen at the adder belong to the same cycle. The hold and cascade properties assume one result stage and one B stage.

The bench keeps to the default parameters. It changes the operation code and operands only at falling edges. Before any feedback operation it lets the pipeline fill while ce_p is held low, so each accumulation starts from a known P and a settled product.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int AW       = 18,
  parameter int BW       = 18,
  parameter int PW       = 48,
  parameter int A_STAGES = 1,
  parameter int B_STAGES = 1,
  parameter int M_REG    = 1,
  parameter int C_REG    = 1,
  parameter int CTL_REG  = 1,
  parameter int P_REG    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_a,
  input  logic          ce_b,
  input  logic          ce_c,
  input  logic          ce_m,
  input  logic          ce_ctl,
  input  logic          ce_p,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [PW-1:0] c,
  input  logic [6:0]    op,
  input  logic          sub,
  input  logic          cin,
  input  logic [PW-1:0] casc_in,
  output logic [PW-1:0] p,
  output logic [PW-1:0] casc_out,
  output logic [BW-1:0] b_casc
);
  localparam int MW  = AW + BW;
  localparam int CTW = 9;

  logic signed [AW-1:0] a_d;
  logic signed [BW-1:0] b_d;
  logic signed [MW-1:0] prod;
  logic        [MW-1:0] m_d;
  logic        [PW-1:0] c_d;
  logic        [6:0]    ctl_op;
  logic                 ctl_sub;
  logic                 ctl_cin;
  logic        [PW-1:0] p_fb, prod_ext;
  logic        [PW-1:0] x_v, y_v, z_v, sum, res;

  generate
    if (A_STAGES == 0) begin : g_a0
      assign a_d = a;
    end else begin : g_a
      logic [A_STAGES-1:0][AW-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else if (ce_a) begin
          sr[0] <= a;
          for (int k = 1; k < A_STAGES; k++) sr[k] <= sr[k-1];
        end
      end
      assign a_d = sr[A_STAGES-1];
    end

    if (B_STAGES == 0) begin : g_b0
      assign b_d = b;
    end else begin : g_b
      logic [B_STAGES-1:0][BW-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else if (ce_b) begin
          sr[0] <= b;
          for (int k = 1; k < B_STAGES; k++) sr[k] <= sr[k-1];
        end
      end
      assign b_d = sr[B_STAGES-1];
    end
  endgenerate

  assign b_casc = b_d;
  assign prod   = a_d * b_d;

  generate
    if (M_REG != 0) begin : g_m
      logic [MW-1:0] q;
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (ce_m) q <= prod;
      assign m_d = q;
    end else begin : g_m0
      assign m_d = prod;
    end

    if (C_REG != 0) begin : g_c
      logic [PW-1:0] q;
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (ce_c) q <= c;
      assign c_d = q;
    end else begin : g_c0
      assign c_d = c;
    end

    if (CTL_REG != 0) begin : g_ctl
      logic [CTW-1:0] q;
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (ce_ctl) q <= {op, sub, cin};
      assign {ctl_op, ctl_sub, ctl_cin} = q;
    end else begin : g_ctl0
      assign {ctl_op, ctl_sub, ctl_cin} = {op, sub, cin};
    end
  endgenerate

  assign prod_ext = {{(PW-MW){m_d[MW-1]}}, m_d};

  wire x_prod = (ctl_op[1:0] == 2'b01);
  wire y_prod = (ctl_op[3:2] == 2'b01);

  always_comb begin
    x_v = '0;
    y_v = '0;
    if (x_prod && y_prod) begin
      x_v = prod_ext;
    end else if (!x_prod && !y_prod) begin
      if (ctl_op[1:0] == 2'b10) x_v = p_fb;
      if (ctl_op[3:2] == 2'b11) y_v = c_d;
    end
    case (ctl_op[6:4])
      3'b001:  z_v = casc_in;
      3'b010:  z_v = p_fb;
      3'b011:  z_v = c_d;
      default: z_v = '0;
    endcase
  end

  assign sum = x_v + y_v + {{(PW-1){1'b0}}, ctl_cin};
  assign res = ctl_sub ? (z_v - sum) : (z_v + sum);

  generate
    if (P_REG != 0) begin : g_p
      logic [PW-1:0] q;
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (ce_p) q <= res;
      assign p    = q;
      assign p_fb = q;
    end else begin : g_p0
      assign p    = res;
      assign p_fb = '0;
    end
  endgenerate

  assign casc_out = p;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int AW       = 18,
  parameter int BW       = 18,
  parameter int PW       = 48,
  parameter int B_STAGES = 1,
  parameter int P_REG    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_b,
  input logic              ce_p,
  input logic [BW-1:0]     b,
  input logic [PW-1:0]     p,
  input logic [BW-1:0]     b_casc,
  input logic [6:0]        op_q,
  input logic              sub_q,
  input logic              cin_q,
  input logic [AW+BW-1:0]  m_q
);
  localparam int MW = AW + BW;
  logic [PW-1:0] m_ext, cin_ext, lone_exp;
  assign m_ext    = {{(PW-MW){m_q[MW-1]}}, m_q};
  assign cin_ext  = {{(PW-1){1'b0}}, cin_q};
  assign lone_exp = sub_q ? (-cin_ext) : cin_ext;

  generate
    if (P_REG != 0) begin : g_p
      AST_RESET_P: assert property (@(posedge clk) rst |=> p == '0); // R9
      AST_HOLD_P: assert property (@(posedge clk) disable iff (rst)
        !ce_p |=> $stable(p)); // R10
      AST_MAC_ACC: assert property (@(posedge clk) disable iff (rst)
        (ce_p && op_q == 7'b010_01_01 && !sub_q) |=>
        p == $past(p) + $past(m_ext) + $past(cin_ext)); // R7
      AST_LONE_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (ce_p && op_q[6:4] == 3'b000 &&
         ((op_q[1:0] == 2'b01) != (op_q[3:2] == 2'b01))) |=>
        p == $past(lone_exp)); // R6
    end
    if (B_STAGES == 1) begin : g_b
      AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        !ce_b |=> $stable(b_casc)); // R10
      AST_B_CASC: assert property (@(posedge clk) disable iff (rst)
        ce_b |=> b_casc == $past(b)); // R11
    end
  endgenerate
endmodule

bind mac_slice mac_slice_chk #(.AW(AW), .BW(BW), .PW(PW), .B_STAGES(B_STAGES), .P_REG(P_REG)) u_chk (
  .clk(clk), .rst(rst), .ce_b(ce_b), .ce_p(ce_p), .b(b), .p(p), .b_casc(b_casc),
  .op_q(ctl_op), .sub_q(ctl_sub), .cin_q(ctl_cin), .m_q(m_d)
);

// File: tb/mac_slice_test.sv
`timescale 1ns/1ps
module mac_slice_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_a = 1, ce_b = 1, ce_c = 1, ce_m = 1, ce_ctl = 1, ce_p = 1;
  logic [17:0] a = '0, b = '0;
  logic [47:0] c = '0, casc_in = '0;
  logic [6:0]  op = '0;
  logic        sub = 0, cin = 0;
  logic [47:0] p, casc_out;
  logic [17:0] b_casc;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mac_slice uut (.clk, .rst, .ce_a, .ce_b, .ce_c, .ce_m, .ce_ctl, .ce_p,
    .a, .b, .c, .op, .sub, .cin, .casc_in, .p, .casc_out, .b_casc);

  function automatic logic [47:0] prod48(logic [17:0] x, logic [17:0] y);
    logic signed [47:0] sx, sy;
    sx = $signed(x);
    sy = $signed(y);
    return sx * sy;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
    if (casc_out !== act && act === p) begin
      n_fail++;
      $display("FAIL R11 casc_out actual=%h expected=%h", casc_out, p);
    end
  endtask

  task automatic do_reset();
    rst = 1; ce_a = 1; ce_b = 1; ce_c = 1; ce_m = 1; ce_ctl = 1; ce_p = 1;
    op = '0; sub = 0; cin = 0; a = '0; b = '0; c = '0; casc_in = '0;
    step(2);
    rst = 0;
  endtask

  task automatic shot(logic [6:0] o, logic s, logic ci, logic [17:0] av, logic [17:0] bv,
                      logic [47:0] cv, logic [47:0] kv);
    op = o; sub = s; cin = ci; a = av; b = bv; c = cv; casc_in = kv;
    step(3);
  endtask

  task automatic t_reset();
    shot(7'b000_01_01, 0, 0, 18'd100, 18'd100, '0, '0);
    do_reset();
    check("R9 p", p, '0);
    check("R9 b_casc", {30'd0, b_casc}, '0);
    check("R9 casc_out", casc_out, '0);
  endtask

  task automatic t_product();
    shot(7'b000_01_01, 0, 0, 18'h3FFFD, 18'd5, '0, '0);
    check("R1 neg*pos", p, 48'hFFFF_FFFF_FFF1);
    shot(7'b000_01_01, 0, 0, 18'h20000, 18'h20000, '0, '0);
    check("R1 min*min", p, 48'h0004_0000_0000);
    shot(7'b000_01_01, 0, 0, 18'h1FFFF, 18'h20000, '0, '0);
    check("R1 max*min", p, prod48(18'h1FFFF, 18'h20000));
  endtask

  task automatic t_sub();
    shot(7'b011_01_01, 1, 0, 18'd7, 18'd9, 48'd1000, '0);
    check("R2 subtract", p, 48'd937);
    shot(7'b011_01_01, 0, 0, 18'd7, 18'd9, 48'd1000, '0);
    check("R2 add", p, 48'd1063);
  endtask

  task automatic t_cin();
    shot(7'b000_00_00, 0, 1, '0, '0, '0, '0);
    check("R3 cin only", p, 48'd1);
    shot(7'b011_00_00, 1, 1, '0, '0, '0, '0);
    check("R3 borrow wrap", p, '1);
  endtask

  task automatic t_csel();
    shot(7'b011_11_00, 0, 0, '0, '0, 48'h7FFF_FFFF_FFFF, '0);
    check("R4 2C wrap", p, 48'hFFFF_FFFF_FFFE);
  endtask

  task automatic t_casc();
    shot(7'b001_00_00, 0, 0, '0, '0, '0, 48'h1234_5678_9ABC);
    check("R5 cascade in", p, 48'h1234_5678_9ABC);
    check("R11 casc_out", casc_out, 48'h1234_5678_9ABC);
  endtask

  task automatic t_illegal();
    shot(7'b011_00_01, 0, 0, 18'd50, 18'd50, 48'd55, '0);
    check("R6 X-only product", p, 48'd55);
    shot(7'b000_01_10, 0, 1, 18'd50, 18'd50, 48'd55, '0);
    check("R6 Y-only product", p, 48'd1);
  endtask

  task automatic t_mac();
    do_reset();
    ce_p = 0; op = 7'b010_01_01; a = 18'h3FC18; b = 18'd300;
    step(3);
    ce_p = 1; step(5) ; ce_p = 0;
    check("R7 mac x5", p, prod48(18'h3FC18, 18'd300) * 5);
    a = 18'd9; b = 18'd9; op = 7'b000_01_01;
    step(4);
    check("R10 p held", p, prod48(18'h3FC18, 18'd300) * 5);
  endtask

  task automatic t_xp();
    do_reset();
    ce_p = 0; op = 7'b000_11_10; c = 48'd11;
    step(3);
    ce_p = 1; step(4); ce_p = 0;
    check("R8 P+C x4", p, 48'd44);
  endtask

  task automatic t_bcasc();
    do_reset();
    b = 18'h2AAAA;
    step(1);
    check("R11 b_casc", {30'd0, b_casc}, {30'd0, 18'h2AAAA});
    ce_b = 0; b = 18'h15555;
    step(2);
    check("R10 b held", {30'd0, b_casc}, {30'd0, 18'h2AAAA});
    ce_b = 1;
  endtask

  task automatic t_latency();
    do_reset();
    shot(7'b000_01_01, 0, 0, 18'd2, 18'd3, '0, '0);
    step(1);
    a = 18'd4;
    step(2);
    check("R12 before third edge", p, 48'd6);
    step(1);
    check("R12 at third edge", p, 48'd12);
  endtask

  initial begin
    step(1);
    do_reset();
    t_reset();
    t_product();
    t_sub();
    t_cin();
    t_csel();
    t_casc();
    t_illegal();
    t_mac();
    t_xp();
    t_bcasc();
    t_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule